// File: doc/BRIEF.md
# Level-1 Latency Pipeline Buffer

This block keeps digitized front-end samples in a circular store for as long as the first-level trigger takes to decide on an event. One sample is written on every pipeline clock, whatever the trigger or the readout side is doing, so the block never has dead time. When an accept strobe arrives, the sample written a programmed number of cycles earlier is copied into a small readout queue together with an event number. Samples that are never accepted are overwritten when the write pointer comes round again.

The readout side is a valid/ready stream. When the queue is full, an accepted event is dropped and a sticky overflow flag is raised. The pipeline is never stalled. Accepts are not taken until the circular store has been written all the way round once after reset, so a freshly reset block never hands out stale contents.

Top module: `l1_latency_pipe`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the write position, the event counter, the readout queue and the overflow flag. After reset, `out_valid` and `ovf_flag` read 0.
- R2: A sample is written on every clock edge, with no exception for accepts, readout stalls or a full queue. Captures made after any such condition still return correctly aligned data.
- R3: An accept that is high in cycle k (counted from the first cycle after reset) captures the sample that was presented in cycle k − `lat_cfg`. This holds for every `lat_cfg` from 1 to DEPTH−1.
- R4: In a cycle where `l1_accept` is low, nothing enters the readout queue. The rejected sample stays in the store until the write pointer overwrites it.
- R5: During the first DEPTH cycles after reset (cycles 0 to DEPTH−1), accepts are ignored. They neither enqueue anything nor advance the event counter.
- R6: Every accept that is taken (not ignored under R5) carries a TAG_W-bit event number. The first accept taken after reset carries 0. The number rises by 1 for each accept taken, including accepts dropped under R8.
- R7: Accepts on consecutive cycles each capture their own sample, lat_cfg cycles before their own cycle.
- R8: An accept taken while the queue already holds FIFO_DEPTH entries is dropped and sets `ovf_flag`. The flag then stays at 1 until the next reset. Whether the queue counts as full is judged before any pop in the same cycle.
- R9: Events leave the queue in order. An entry is removed at a clock edge where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_tag` hold their values.
- R10: An event pushed at a clock edge is visible on `out_valid` in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | DATA_W | Digitized sample, one per clock |
| l1_accept | input | 1 | Trigger accept strobe for the current cycle |
| lat_cfg | input | $clog2(DEPTH) | Trigger latency in cycles (1..DEPTH−1, nominally 128) |
| out_valid | output | 1 | Readout queue head is valid |
| out_ready | input | 1 | Consumer takes the head this cycle |
| out_data | output | DATA_W | Captured sample at queue head |
| out_tag | output | TAG_W | Event number at queue head |
| ovf_flag | output | 1 | Sticky overflow, an event was dropped |

## Verification
The bench builds the block with DEPTH = 32, FIFO_DEPTH = 4, DATA_W = 16 and TAG_W = 16. A store of 32 slots lets the fill gate expire, and the pointer wrap several times, within a few hundred cycles. A four-entry queue can be driven into overflow with a short burst of accepts while the consumer holds ready low. The bench exercises the latency at both ends of its range (1 and 31) and at a value in between. It also runs back-to-back accepts, so the tap arithmetic is checked across the wrap boundary.

// File: rtl/l1_pipe_pkg.sv
package l1_pipe_pkg;
  // slot written 'lat' cycles before the slot at 'wr'
  function automatic int unsigned ring_slot(input int unsigned wr,
                                            input int unsigned lat,
                                            input int unsigned depth);
    return (wr + depth - lat) % depth;
  endfunction

  // write position after 'wr', wrapping at depth
  function automatic int unsigned ring_next(input int unsigned wr,
                                            input int unsigned depth);
    return (wr == depth - 1) ? 0 : wr + 1;
  endfunction
endpackage

// File: rtl/l1_pipe_ring.sv
module l1_pipe_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic [AW-1:0]     lat,
  output logic              filled,
  output logic [DATA_W-1:0] tap
);
  import l1_pipe_pkg::*;

  logic [DATA_W-1:0] store [DEPTH];
  logic [AW-1:0]     wr_pos;
  logic [AW-1:0]     rd_pos;

  assign rd_pos = AW'(ring_slot(32'(wr_pos), 32'(lat), DEPTH));
  assign tap    = store[rd_pos];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pos <= '0;
      filled <= 1'b0;
    end else begin
      wr_pos <= AW'(ring_next(32'(wr_pos), DEPTH));
      if (32'(wr_pos) == DEPTH - 1) filled <= 1'b1;
    end
  end

  // storage is written every cycle: no dead time
  always_ff @(posedge clk) begin
    store[wr_pos] <= din;
  end
endmodule

// File: rtl/l1_trig_ctl.sv
module l1_trig_ctl #(
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             filled,
  input  logic             q_full,
  output logic             acc_taken,
  output logic             push,
  output logic [TAG_W-1:0] tag_cnt,
  output logic             ovf
);
  assign acc_taken = accept & filled;
  assign push      = acc_taken & ~q_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_cnt <= '0;
      ovf     <= 1'b0;
    end else begin
      if (acc_taken)          tag_cnt <= tag_cnt + 1'b1;
      if (acc_taken & q_full) ovf     <= 1'b1;
    end
  end
endmodule

// File: rtl/l1_rdo_fifo.sv
module l1_rdo_fifo #(
  parameter int W  = 32,
  parameter int FD = 8,
  localparam int PW = (FD > 1) ? $clog2(FD) : 1,
  localparam int CW = $clog2(FD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          ready,
  output logic          valid,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]  slots [FD];
  logic [PW-1:0] head;
  logic [PW-1:0] tail;
  logic          pop;

  assign valid = (cnt != '0);
  assign full  = (32'(cnt) == FD);
  assign pop   = valid & ready;
  assign dout  = slots[head];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (32'(p) == FD - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (push) tail <= bump(tail);
      if (pop)  head <= bump(head);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[tail] <= din;
  end
endmodule

// File: rtl/l1_latency_pipe.sv
module l1_latency_pipe #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 256,
  parameter int FIFO_DEPTH = 8,
  parameter int TAG_W      = 16,
  localparam int AW        = $clog2(DEPTH),
  localparam int EW        = DATA_W + TAG_W,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] smp_in,
  input  logic              l1_accept,
  input  logic [AW-1:0]     lat_cfg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic              ovf_flag
);
  // named internal events, visible to the bound checker
  logic              filled;
  logic [DATA_W-1:0] tap;
  logic              acc_taken;
  logic              push;
  logic              q_full;
  logic [CW-1:0]     q_cnt;
  logic [TAG_W-1:0]  tag_cnt;
  logic [EW-1:0]     q_out;

  l1_pipe_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst(rst), .din(smp_in), .lat(lat_cfg),
    .filled(filled), .tap(tap)
  );

  l1_trig_ctl #(.TAG_W(TAG_W)) u_ctl (
    .clk(clk), .rst(rst), .accept(l1_accept), .filled(filled),
    .q_full(q_full), .acc_taken(acc_taken), .push(push),
    .tag_cnt(tag_cnt), .ovf(ovf_flag)
  );

  l1_rdo_fifo #(.W(EW), .FD(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din({tag_cnt, tap}),
    .ready(out_ready), .valid(out_valid), .dout(q_out),
    .full(q_full), .cnt(q_cnt)
  );

  assign out_data = q_out[DATA_W-1:0];
  assign out_tag  = q_out[EW-1:DATA_W];
endmodule

// File: rtl/l1_pipe_checker.sv
module l1_pipe_checker #(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int TAG_W      = 16,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              filled,
  input logic              acc_taken,
  input logic              push,
  input logic              q_full,
  input logic [CW-1:0]     q_cnt,
  input logic [TAG_W-1:0]  tag_cnt,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [TAG_W-1:0]  out_tag,
  input logic              ovf_flag
);
  p_fill_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !filled |-> !push);

  p_tag_step_r6: assert property (@(posedge clk) disable iff (rst)
    acc_taken |=> (tag_cnt == $past(tag_cnt) + 1'b1));

  p_tag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !acc_taken |=> $stable(tag_cnt));

  p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_taken && q_full) |=> ovf_flag);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    32'(q_cnt) <= FIFO_DEPTH);

  p_head_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

  p_visible_r10: assert property (@(posedge clk) disable iff (rst)
    push |=> out_valid);
endmodule

bind l1_latency_pipe l1_pipe_checker #(
  .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst(rst), .filled(filled), .acc_taken(acc_taken),
  .push(push), .q_full(q_full), .q_cnt(q_cnt), .tag_cnt(tag_cnt),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_tag(out_tag), .ovf_flag(ovf_flag)
);

// File: tb/test_l1_latency_pipe.sv
module test_l1_latency_pipe;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 32;
  localparam int FD     = 4;
  localparam int TAG_W  = 16;
  localparam int AW     = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] smp_in = '0;
  logic              l1_accept = 1'b0;
  logic [AW-1:0]     lat_cfg = AW'(20);
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic [TAG_W-1:0]  out_tag;
  logic              ovf_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tag_m = 0;
  bit ovf_m = 1'b0;
  logic [31:0] mq[$];

  always #10 clk = ~clk;

  l1_latency_pipe #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FIFO_DEPTH(FD), .TAG_W(TAG_W)) i_l1_latency_pipe (
    .clk(clk), .rst(rst), .smp_in(smp_in), .l1_accept(l1_accept),
    .lat_cfg(lat_cfg), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_tag(out_tag), .ovf_flag(ovf_flag)
  );

  // distinct sample value for every cycle number
  function automatic logic [DATA_W-1:0] pat(input int k);
    return DATA_W'(k * 40503 + 4660);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare the outputs with the model, then drive one cycle and update the model
  task automatic step(input bit acc, input bit rdy, input string req);
    bit pop;
    chk(req, "out_valid", int'(out_valid), int'(mq.size() != 0));
    if (mq.size() != 0 && out_valid) begin
      chk(req, "out_data", int'(out_data), int'(mq[0][15:0]));
      chk(req, "out_tag", int'(out_tag), int'(mq[0][31:16]));
    end
    chk(req, "ovf_flag", int'(ovf_flag), int'(ovf_m));
    smp_in    = pat(cyc);
    l1_accept = acc;
    out_ready = rdy;
    pop = rdy && (mq.size() != 0);
    if (acc && cyc >= DEPTH) begin
      if (mq.size() == FD) ovf_m = 1'b1;
      else mq.push_back({16'(tag_m), pat(cyc - int'(lat_cfg))});
      tag_m++;
    end
    if (pop) void'(mq.pop_front());
    cyc++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    l1_accept = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    tag_m = 0;
    ovf_m = 1'b0;
    mq.delete();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "ovf_flag after reset", int'(ovf_flag), 0);
  endtask

  task automatic t_fill_gate();
    lat_cfg = AW'(20);
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, "R5");
    chk("R5", "queue empty after gated accepts", int'(out_valid), 0);
    step(1'b1, 1'b0, "R5");          // first accept taken: tag 0, R6
    step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b1, "R10");
  endtask

  task automatic t_latency(input int lat);
    lat_cfg = AW'(lat);
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b1, "R3");
      step(1'b0, 1'b1, "R10");
      step(1'b0, 1'b1, "R3");
    end
  endtask

  task automatic t_reject();
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, "R4");
    chk("R4", "nothing queued on reject", int'(out_valid), 0);
  endtask

  task automatic t_back_to_back();
    lat_cfg = AW'(7);
    step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, "R7");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R9");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R7");
  endtask

  task automatic t_overflow();
    lat_cfg = AW'(13);
    for (int i = 0; i < FD + 2; i++) step(1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, "R8");
    chk("R8", "ovf_flag raised", int'(ovf_flag), 1);
    for (int i = 0; i < FD + 2; i++) step(1'b0, 1'b1, "R8");
    step(1'b1, 1'b1, "R6");          // tag skips the dropped events
    for (int i = 0; i < 40; i++) step(i % 3 == 0, 1'b1, "R2");
    chk("R8", "ovf_flag still set", int'(ovf_flag), 1);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_gate();
    t_latency(20);
    t_latency(1);
    t_latency(DEPTH - 1);
    t_reject();
    t_back_to_back();
    t_overflow();
    t_reset();
    t_fill_gate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule